// File: doc/BRIEF.md
# Direct Digital Synthesis Tone Sequencer

This block generates an audio tone as a stream of 8-bit unsigned samples for an external resistor DAC. A 32-bit phase accumulator grows by a tuning step on every clock edge. Its upper byte selects one of 256 entries in a one-period sine table, and the table value is registered onto the sample output.

The tuning step is taken from a short table of note steps, a C major scale by default. A one-second timer moves the table pointer to the next note. The block therefore plays the scale over and over with no outside control. Both tables are computed from parameters when the design elaborates, so no memory image file is needed. The clock rate, the note dwell time and the widths are parameters. The defaults suit a 25 MHz clock.

Top module: `dds_tone_seq`

## Requirements
- R1: A PHASE_W-bit (32) phase accumulator adds the current note step on every rising clock edge outside reset and wraps modulo 2^PHASE_W.
- R2: The table address is accumulator bits [PHASE_W-1 : PHASE_W-ADDR_W], which is [31:24] by default.
- R3: Sine entry i is floor(127*sin(2*pi*i/256) + 128). Every sample therefore lies in 1..255, and over many periods the samples swing from near 1 to near 255.
- R4: The sample output is registered. It shows the table entry addressed by the accumulator value held before the edge, which is one cycle of latency.
- R5: The step for note k is floor(2^32 * f_k / CLK_HZ). The frequencies f_0..f_7 are 261.63, 293.66, 329.63, 349.23, 392.00, 440.00, 493.88 and 523.25 Hz. Entry 0 is used first after reset.
- R6: The note pointer holds for TICK_CYCLES clocks, 25,000,000 by default, and then advances by one. The new step is first added on the edge that follows the advance.
- R7: After the last entry (index NOTES-1 = 7), the note pointer wraps back to entry 0.
- R8: A synchronous reset clears the accumulator, the note pointer and the dwell counter. During reset the sample output is the midpoint 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 25 MHz by default |
| rst | input | 1 | Synchronous active-high reset |
| sample_o | output | SAMP_W (8) | Unsigned offset-binary sine sample for the DAC |

## Verification
Each sample is due one edge after the accumulator value that addresses it. An accumulator value in turn reflects the step of the note that was current before that edge. A note change therefore shows up in the phase one edge after the dwell counter wraps, and in the sample one edge later still. The bench keeps a cycle-exact reference: it advances a model of accumulator, dwell counter and pointer at every rising edge and compares sample_o at the next falling edge, so each result is taken in the cycle it is due. The dwell time and clock rate are overridden to small values so that several full scale loops and many sine periods fit in the run.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // Frequency in Hz of scale degree k; degrees past 7 repeat an octave up.
    function automatic real note_hz(input int k);
        real f;
        case (k)
            0: f = 261.63;
            1: f = 293.66;
            2: f = 329.63;
            3: f = 349.23;
            4: f = 392.00;
            5: f = 440.00;
            6: f = 493.88;
            7: f = 523.25;
            default: f = 2.0 * note_hz(k - 8);
        endcase
        return f;
    endfunction

    // Offset-binary sine code for entry i of a depth-entry period.
    function automatic int sine_code(input int i, input int depth, input int amp, input int mid);
        return $rtoi(real'(amp) * $sin(2.0 * PI_R * real'(i) / real'(depth)) + real'(mid));
    endfunction

    // Phase step that yields frequency f at a clock of clk_hz.
    function automatic int phase_step(input real f, input int clk_hz);
        return $rtoi(4294967296.0 * f / real'(clk_hz));
    endfunction

endpackage

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
    parameter int ADDR_W = 8,
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SAMP_W-1:0] data_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int MID   = 1 << (SAMP_W - 1);
    localparam int AMP   = MID - 1;

    logic [SAMP_W-1:0] tab_w [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tab
        assign tab_w[gi] = SAMP_W'(dds_pkg::sine_code(gi, DEPTH, AMP, MID));
    end

    typedef struct packed {
        logic [SAMP_W-1:0] data;
    } rom_t;

    rom_t rom_d, rom_q;

    always_comb begin
        rom_d = rom_q;
        if (rst) begin
            rom_d.data = SAMP_W'(MID);
        end else begin
            rom_d.data = tab_w[addr_i];
        end
    end

    always_ff @(posedge clk) begin
        rom_q <= rom_d;
    end

    assign data_o = rom_q.data;
endmodule

// File: rtl/dds_note_seq.sv
module dds_note_seq #(
    parameter int CLK_HZ      = 25_000_000,
    parameter int TICK_CYCLES = 25_000_000,
    parameter int NOTES       = 8,
    parameter int PHASE_W     = 32,
    parameter int IDX_W       = 3
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PHASE_W-1:0] step_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               adv_o
);
    localparam int TICK_W = $clog2(TICK_CYCLES + 1);

    logic [PHASE_W-1:0] step_tab_w [NOTES];

    for (genvar gk = 0; gk < NOTES; gk++) begin : g_step
        assign step_tab_w[gk] = PHASE_W'(dds_pkg::phase_step(dds_pkg::note_hz(gk), CLK_HZ));
    end

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [IDX_W-1:0]  idx;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_tick;

    always_comb begin
        seq_d     = seq_q;
        last_tick = (seq_q.tick == TICK_W'(TICK_CYCLES - 1));
        if (rst) begin
            seq_d = '0;
        end else if (last_tick) begin
            seq_d.tick = '0;
            if (seq_q.idx == IDX_W'(NOTES - 1)) begin
                seq_d.idx = '0;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
            end
        end else begin
            seq_d.tick = seq_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    assign step_o = step_tab_w[seq_q.idx];
    assign idx_o  = seq_q.idx;
    assign adv_o  = last_tick;
endmodule

// File: rtl/dds_tone_seq.sv
module dds_tone_seq #(
    parameter int CLK_HZ      = 25_000_000,
    parameter int TICK_CYCLES = CLK_HZ,
    parameter int PHASE_W     = 32,
    parameter int ADDR_W      = 8,
    parameter int SAMP_W      = 8,
    parameter int NOTES       = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SAMP_W-1:0] sample_o
);
    localparam int IDX_W = (NOTES > 1) ? $clog2(NOTES) : 1;

    logic [PHASE_W-1:0] step_w;
    logic [IDX_W-1:0]   idx_w;
    logic               adv_w;

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
    } acc_t;

    acc_t acc_d, acc_q;

    dds_note_seq #(
        .CLK_HZ      (CLK_HZ),
        .TICK_CYCLES (TICK_CYCLES),
        .NOTES       (NOTES),
        .PHASE_W     (PHASE_W),
        .IDX_W       (IDX_W)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .step_o (step_w),
        .idx_o  (idx_w),
        .adv_o  (adv_w)
    );

    always_comb begin
        acc_d = acc_q;
        if (rst) begin
            acc_d.acc = '0;
        end else begin
            acc_d.acc = acc_q.acc + step_w;
        end
    end

    always_ff @(posedge clk) begin
        acc_q <= acc_d;
    end

    dds_sine_rom #(
        .ADDR_W (ADDR_W),
        .SAMP_W (SAMP_W)
    ) u_rom (
        .clk    (clk),
        .rst    (rst),
        .addr_i (acc_q.acc[PHASE_W-1 -: ADDR_W]),
        .data_o (sample_o)
    );
endmodule

// File: rtl/dds_tone_seq_chk.sv
module dds_tone_seq_chk #(
    parameter int TICK_CYCLES = 25_000_000,
    parameter int NOTES       = 8,
    parameter int PHASE_W     = 32,
    parameter int SAMP_W      = 8,
    parameter int IDX_W       = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [PHASE_W-1:0] acc,
    input logic [PHASE_W-1:0] step,
    input logic [IDX_W-1:0]   idx,
    input logic               adv,
    input logic [SAMP_W-1:0]  sample
);
    localparam int CNT_W = $clog2(TICK_CYCLES + 1);

    logic [CNT_W-1:0] dwell_q;

    always_ff @(posedge clk) begin
        if (rst || adv) begin
            dwell_q <= '0;
        end else begin
            dwell_q <= dwell_q + 1'b1;
        end
    end

    // R1: accumulator advances by the step that was applied
    p_acc_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> acc == $past(acc) + $past(step));

    // R3: no sample ever reaches code 0
    p_sample_range_r3: assert property (@(posedge clk) disable iff (rst)
        sample != '0);

    // R6: advance only after a full dwell
    p_dwell_len_r6: assert property (@(posedge clk) disable iff (rst)
        adv |-> dwell_q == CNT_W'(TICK_CYCLES - 1));

    // R6: pointer holds between advances
    p_idx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(idx));

    // R7: last entry wraps to zero
    p_idx_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (adv && idx == IDX_W'(NOTES - 1)) |=> idx == '0);

    // R8: reset clears state and parks the output at midscale
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (acc == '0 && idx == '0 && sample == SAMP_W'(1 << (SAMP_W - 1))));
endmodule

bind dds_tone_seq dds_tone_seq_chk #(
    .TICK_CYCLES (TICK_CYCLES),
    .NOTES       (NOTES),
    .PHASE_W     (PHASE_W),
    .SAMP_W      (SAMP_W),
    .IDX_W       (IDX_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .acc    (acc_q.acc),
    .step   (step_w),
    .idx    (idx_w),
    .adv    (adv_w),
    .sample (sample_o)
);

// File: tb/dds_tone_seq_test.sv
module dds_tone_seq_test;
    localparam int  CLK_HZ = 25_000;
    localparam int  TICK   = 500;
    localparam int  NN     = 8;
    localparam real PI_B   = 3.14159265358979323846;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sample_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int          sin_m [256];
    logic [31:0] inc_m [NN];
    real         freq_m [NN];

    logic [31:0] m_acc;
    int          m_tick;
    int          m_idx;
    int          m_samp;
    int          seen_max;
    int          seen_min;

    always #5 clk = ~clk;

    dds_tone_seq #(.CLK_HZ(CLK_HZ), .TICK_CYCLES(TICK)) uut (
        .clk      (clk),
        .rst      (rst),
        .sample_o (sample_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // one rising edge of the reference, then compare at the falling edge
    task automatic step_cmp(input string req);
        @(posedge clk);
        if (rst) begin
            m_acc  = '0;
            m_tick = 0;
            m_idx  = 0;
            m_samp = 128;
        end else begin
            m_samp = sin_m[m_acc[31:24]];
            m_acc  = m_acc + inc_m[m_idx];
            if (m_tick == TICK - 1) begin
                m_tick = 0;
                m_idx  = (m_idx + 1) % NN;
            end else begin
                m_tick++;
            end
        end
        @(negedge clk);
        if (int'(sample_o) > seen_max) seen_max = int'(sample_o);
        if (int'(sample_o) < seen_min) seen_min = int'(sample_o);
        check(req, int'(sample_o), m_samp);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step_cmp("R8 reset midscale");
        check("R8 reset output", int'(sample_o), 128);
    endtask

    task automatic t_first_note();
        rst = 1'b0;
        step_cmp("R4 first sample from zero phase");
        check("R4 R2 first sample", int'(sample_o), 128);
        for (int i = 1; i < TICK - 10; i++) step_cmp("R1 R2 R3 R4 R5 note 0");
    endtask

    task automatic t_note_edge();
        for (int i = 0; i < 30; i++) step_cmp("R5 R6 note boundary");
        check("R6 pointer moved", m_idx, 1);
    endtask

    task automatic t_scale_wrap();
        seen_max = 0;
        seen_min = 255;
        for (int i = 0; i < 2 * NN * TICK; i++) step_cmp("R5 R6 R7 scale loop");
        check("R3 swing top", int'(seen_max >= 250), 1);
        check("R3 swing bottom", int'(seen_min <= 6), 1);
        check("R3 never zero", int'(seen_min >= 1), 1);
    endtask

    task automatic t_mid_reset();
        for (int i = 0; i < 5 * TICK + 123; i++) step_cmp("R6 R7 before reset");
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 2; i++) step_cmp("R8 mid-run reset");
        check("R8 output midscale", int'(sample_o), 128);
        rst = 1'b0;
        for (int i = 0; i < TICK + 50; i++) step_cmp("R8 restart from note 0");
        check("R8 pointer restarted", m_idx, 1);
    endtask

    initial begin
        freq_m = '{261.63, 293.66, 329.63, 349.23, 392.00, 440.00, 493.88, 523.25};
        for (int i = 0; i < 256; i++)
            sin_m[i] = $rtoi(127.0 * $sin(2.0 * PI_B * real'(i) / 256.0) + 128.0);
        for (int k = 0; k < NN; k++)
            inc_m[k] = 32'($rtoi(4294967296.0 * freq_m[k] / real'(CLK_HZ)));
        m_acc    = '0;
        m_tick   = 0;
        m_idx    = 0;
        m_samp   = 128;
        seen_max = 0;
        seen_min = 255;
        check("R3 table peak", sin_m[64], 255);
        check("R3 table trough", sin_m[192], 1);
        @(negedge clk);
        t_reset_state();
        t_first_note();
        t_note_edge();
        t_scale_wrap();
        t_mid_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule